// File: doc/BRIEF.md
# Ethernet Receive Address Filter

This block makes the keep-or-drop decision for one received Ethernet frame once the frame has ended. It is given the destination address, a precomputed CRC-32 of that address, the final byte count and the error flags. It sorts the destination into one of three classes: individual (unicast), group (multicast) or all-ones (broadcast). It then applies the matching rule for that class, the length rule and the error rule. The result is one accept bit and an eight-bit receive status word. The status word uses fixed bit positions, because the logic that writes packet headers stores it as is.

The station address, the group hash table and the option bits come from static configuration inputs. Two slots at the top of the hash table also serve as remote commands. When the automatic transmit-disable option is on, a group frame that hashes to the second-highest slot sets a transmitter-disable output. A group frame that hashes to the highest slot clears it again.

An address byte `k` (k = 0 is the first byte on the wire) sits in bits `[8k+7:8k]` of both address ports. The group flag is bit 0 of byte 0.

Top module: `rx_addr_filter`

## Requirements
- R1: When promiscuous mode is clear, a unicast frame (dest_addr bit 0 = 0) passes the address rule only if all six bytes equal station_addr.
- R2: When promiscuous mode is set, every unicast frame passes the address rule, whatever its destination.
- R3: A destination of all ones passes the address rule only when cfg_accept_bcast is 1. The hash table is not consulted for it.
- R4: A group destination that is not all ones passes only when cfg_accept_mcast is 1 and hash_table[dest_crc[31:26]] is 1. The index is the top 6 bits of the CRC, and table bit n is bit n%8 of table byte n/8.
- R5: A frame whose frame_len is below 64 is rejected unless cfg_accept_runt is 1. A length of exactly 64 is not a runt.
- R6: A frame with crc_err or align_err is rejected unless cfg_save_err is 1. Status bit 1 is crc_err OR align_err, and status bit 2 is align_err.
- R7: A frame with fifo_ovr is never accepted, and status bit 3 shows fifo_ovr.
- R8: With cfg_monitor set, no frame is accepted. Status bit 6 shows cfg_monitor, and status bit 4 (missed) is set when the frame passed the address, length and error rules but was not stored because of monitor mode.
- R9: Status bit 0 is set when the frame is accepted without a CRC or alignment error. Status bit 5 is 1 for group or broadcast destinations and 0 for unicast. Status bit 7 is always 0.
- R10: accept, rx_status and status_valid update on the clock edge that samples frame_valid = 1. status_valid is high for that one cycle only. accept and rx_status hold until the next frame. All outputs are 0 after reset.
- R11: With cfg_auto_tx set, a group, non-broadcast frame whose hash index is 62 sets tx_disable on the next edge, and one whose index is 63 clears it. This happens regardless of the table contents and of the acceptance decision. Other indexes leave tx_disable unchanged. While cfg_auto_tx is 0, tx_disable is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| frame_valid | input | 1 | One-cycle strobe: frame ended, other frame inputs valid |
| dest_addr | input | 48 | Destination address, byte 0 in bits 7:0 |
| dest_crc | input | 32 | CRC-32 of the destination address |
| frame_len | input | 16 | Final frame length in bytes |
| crc_err | input | 1 | Frame had a CRC error |
| align_err | input | 1 | Frame had an alignment error |
| fifo_ovr | input | 1 | Receive FIFO overran during the frame |
| station_addr | input | 48 | Own physical address, same byte layout |
| hash_table | input | 64 | Group hash table |
| cfg_promisc | input | 1 | Accept every unicast frame |
| cfg_accept_bcast | input | 1 | Accept broadcast frames |
| cfg_accept_mcast | input | 1 | Accept group frames through the hash table |
| cfg_accept_runt | input | 1 | Keep frames shorter than 64 bytes |
| cfg_save_err | input | 1 | Keep frames with CRC or alignment errors |
| cfg_monitor | input | 1 | Check frames but store none |
| cfg_auto_tx | input | 1 | Enable remote transmitter disable/enable by hash slot |
| accept | output | 1 | Frame is to be stored |
| rx_status | output | 8 | Receive status word |
| status_valid | output | 1 | One-cycle strobe: accept and rx_status are new |
| tx_disable | output | 1 | Transmitter held off by remote command |

## Verification
Every result is due exactly one clock edge after the strobe: accept, rx_status, status_valid and tx_disable are all registered from the edge that samples frame_valid. The bench drives each frame on a falling edge and holds the strobe for one cycle. It then compares all four outputs at the following falling edge. One falling edge later it confirms that the strobe has dropped while accept and rx_status are held. The expected word is built by a bench function from the requirement rules, and a separate model follows the transmit-disable state from frame to frame.

// File: rtl/rxf_pkg.sv
package rxf_pkg;
   localparam int ST_OK   = 0;
   localparam int ST_CRC  = 1;
   localparam int ST_ALN  = 2;
   localparam int ST_FOV  = 3;
   localparam int ST_MISS = 4;
   localparam int ST_GRP  = 5;
   localparam int ST_DIS  = 6;
   localparam int ST_W    = 8;

   typedef enum logic [1:0] {
      DST_UNI   = 2'd0,
      DST_GRP   = 2'd1,
      DST_BCAST = 2'd2
   } dst_kind_e;

   typedef struct packed {
      logic crc_bad;
      logic aln_bad;
      logic fifo_bad;
   } rx_err_t;
endpackage

// File: rtl/rxf_addr_class.sv
module rxf_addr_class
   import rxf_pkg::*;
#(
   parameter int ADDR_W    = 48,
   parameter int CRC_W     = 32,
   parameter int HASH_BITS = 6,
   localparam int TBL_W    = 1 << HASH_BITS,
   localparam int N_BYTES  = ADDR_W / 8
) (
   input  logic [ADDR_W-1:0]    dest,
   input  logic [ADDR_W-1:0]    station,
   input  logic [CRC_W-1:0]     dest_crc,
   input  logic [TBL_W-1:0]     table_bits,
   output dst_kind_e            kind,
   output logic                 station_hit,
   output logic                 hash_hit,
   output logic [HASH_BITS-1:0] hash_idx
);
   logic [N_BYTES-1:0] byte_eq;
   logic [N_BYTES-1:0] byte_ones;

   generate
      for (genvar b = 0; b < N_BYTES; b++) begin : g_byte
         assign byte_eq[b]   = (dest[8*b +: 8] == station[8*b +: 8]);
         assign byte_ones[b] = &dest[8*b +: 8];
      end
   endgenerate

   assign station_hit = &byte_eq;
   assign hash_idx    = dest_crc[CRC_W-1 -: HASH_BITS];
   assign hash_hit    = table_bits[hash_idx];

   always_comb begin
      if (&byte_ones)   kind = DST_BCAST;
      else if (dest[0]) kind = DST_GRP;
      else              kind = DST_UNI;
   end
endmodule

// File: rtl/rxf_frame_qual.sv
module rxf_frame_qual
   import rxf_pkg::*;
#(
   parameter int LEN_W   = 16,
   parameter int MIN_LEN = 64
) (
   input  logic [LEN_W-1:0] frame_len,
   input  rx_err_t          errs,
   input  logic             keep_runt,
   input  logic             keep_bad,
   output logic             len_ok,
   output logic             err_ok,
   output logic             any_crc
);
   localparam logic [LEN_W-1:0] MIN_L = LEN_W'(MIN_LEN);

   assign any_crc = errs.crc_bad | errs.aln_bad;
   assign len_ok  = (frame_len >= MIN_L) | keep_runt;
   assign err_ok  = ~any_crc | keep_bad;
endmodule

// File: rtl/rxf_txgate.sv
module rxf_txgate #(
   parameter int HASH_BITS = 6,
   localparam int TBL_W    = 1 << HASH_BITS,
   localparam logic [HASH_BITS-1:0] OFF_IDX = HASH_BITS'(TBL_W - 2),
   localparam logic [HASH_BITS-1:0] ON_IDX  = HASH_BITS'(TBL_W - 1)
) (
   input  logic                 clk,
   input  logic                 rst_n,
   input  logic                 frame_valid,
   input  logic                 enable,
   input  logic                 is_grp,
   input  logic [HASH_BITS-1:0] hash_idx,
   output logic                 tx_disable
);
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)
         tx_disable <= 1'b0;
      else if (!enable)
         tx_disable <= 1'b0;
      else if (frame_valid && is_grp) begin
         if (hash_idx == OFF_IDX)     tx_disable <= 1'b1;
         else if (hash_idx == ON_IDX) tx_disable <= 1'b0;
      end
   end

   a_r11_off_slot: assert property (@(posedge clk) disable iff (!rst_n)
      (frame_valid && enable && is_grp && hash_idx == OFF_IDX) |=> tx_disable);
   a_r11_on_slot: assert property (@(posedge clk) disable iff (!rst_n)
      (frame_valid && enable && is_grp && hash_idx == ON_IDX) |=> !tx_disable);
   a_r11_opt_clear: assert property (@(posedge clk) disable iff (!rst_n)
      !enable |=> !tx_disable);
   a_r11_no_frame_hold: assert property (@(posedge clk) disable iff (!rst_n)
      (!frame_valid && enable) |=> $stable(tx_disable));
endmodule

// File: rtl/rx_addr_filter.sv
module rx_addr_filter
   import rxf_pkg::*;
#(
   parameter int ADDR_W    = 48,
   parameter int CRC_W     = 32,
   parameter int LEN_W     = 16,
   parameter int HASH_BITS = 6,
   parameter int MIN_LEN   = 64
) (
   input  logic                        clk,
   input  logic                        rst_n,
   input  logic                        frame_valid,
   input  logic [ADDR_W-1:0]           dest_addr,
   input  logic [CRC_W-1:0]            dest_crc,
   input  logic [LEN_W-1:0]            frame_len,
   input  logic                        crc_err,
   input  logic                        align_err,
   input  logic                        fifo_ovr,
   input  logic [ADDR_W-1:0]           station_addr,
   input  logic [(1<<HASH_BITS)-1:0]   hash_table,
   input  logic                        cfg_promisc,
   input  logic                        cfg_accept_bcast,
   input  logic                        cfg_accept_mcast,
   input  logic                        cfg_accept_runt,
   input  logic                        cfg_save_err,
   input  logic                        cfg_monitor,
   input  logic                        cfg_auto_tx,
   output logic                        accept,
   output logic [ST_W-1:0]             rx_status,
   output logic                        status_valid,
   output logic                        tx_disable
);
   localparam int TBL_W = 1 << HASH_BITS;

   generate
      if (ADDR_W % 8 != 0 || ADDR_W < 16) begin : g_bad_addr
         $error("rx_addr_filter: ADDR_W must be a whole number of bytes, at least 2");
      end
      if (HASH_BITS < 2 || HASH_BITS > CRC_W) begin : g_bad_hash
         $error("rx_addr_filter: HASH_BITS must lie in 2..CRC_W");
      end
      if (MIN_LEN < 1 || MIN_LEN >= (1 << LEN_W)) begin : g_bad_len
         $error("rx_addr_filter: MIN_LEN must fit in LEN_W bits");
      end
   endgenerate

   dst_kind_e            kind;
   logic                 station_hit, hash_hit;
   logic [HASH_BITS-1:0] hash_idx;
   logic                 len_ok, err_ok, any_crc;
   rx_err_t              errs;
   logic                 addr_ok, pass, accept_d;
   logic [ST_W-1:0]      status_d;

   assign errs = '{crc_bad: crc_err, aln_bad: align_err, fifo_bad: fifo_ovr};

   rxf_addr_class #(
      .ADDR_W(ADDR_W), .CRC_W(CRC_W), .HASH_BITS(HASH_BITS)
   ) u_class (
      .dest(dest_addr), .station(station_addr), .dest_crc(dest_crc),
      .table_bits(hash_table), .kind(kind), .station_hit(station_hit),
      .hash_hit(hash_hit), .hash_idx(hash_idx)
   );

   rxf_frame_qual #(
      .LEN_W(LEN_W), .MIN_LEN(MIN_LEN)
   ) u_qual (
      .frame_len(frame_len), .errs(errs), .keep_runt(cfg_accept_runt),
      .keep_bad(cfg_save_err), .len_ok(len_ok), .err_ok(err_ok), .any_crc(any_crc)
   );

   rxf_txgate #(
      .HASH_BITS(HASH_BITS)
   ) u_txgate (
      .clk(clk), .rst_n(rst_n), .frame_valid(frame_valid), .enable(cfg_auto_tx),
      .is_grp(kind == DST_GRP), .hash_idx(hash_idx), .tx_disable(tx_disable)
   );

   always_comb begin
      unique case (kind)
         DST_UNI:   addr_ok = cfg_promisc | station_hit;
         DST_GRP:   addr_ok = cfg_accept_mcast & hash_hit;
         DST_BCAST: addr_ok = cfg_accept_bcast;
         default:   addr_ok = 1'b0;
      endcase
   end

   assign pass     = addr_ok & len_ok & err_ok;
   assign accept_d = pass & ~errs.fifo_bad & ~cfg_monitor;

   always_comb begin
      status_d          = '0;
      status_d[ST_OK]   = accept_d & ~any_crc;
      status_d[ST_CRC]  = any_crc;
      status_d[ST_ALN]  = errs.aln_bad;
      status_d[ST_FOV]  = errs.fifo_bad;
      status_d[ST_MISS] = pass & cfg_monitor;
      status_d[ST_GRP]  = (kind != DST_UNI);
      status_d[ST_DIS]  = cfg_monitor;
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         accept       <= 1'b0;
         rx_status    <= '0;
         status_valid <= 1'b0;
      end else begin
         status_valid <= frame_valid;
         if (frame_valid) begin
            accept    <= accept_d;
            rx_status <= status_d;
         end
      end
   end

   a_r10_strobe_source: assert property (@(posedge clk) disable iff (!rst_n)
      status_valid |-> $past(frame_valid));
   a_r10_hold: assert property (@(posedge clk) disable iff (!rst_n)
      !status_valid |-> ($stable(accept) && $stable(rx_status)));
   a_r5_runt_drop: assert property (@(posedge clk) disable iff (!rst_n)
      (frame_valid && frame_len < LEN_W'(MIN_LEN) && !cfg_accept_runt) |=> !accept);
   a_r6_err_drop: assert property (@(posedge clk) disable iff (!rst_n)
      (frame_valid && (crc_err || align_err) && !cfg_save_err) |=> !accept);
   a_r7_fifo_drop: assert property (@(posedge clk) disable iff (!rst_n)
      (status_valid && rx_status[ST_FOV]) |-> !accept);
   a_r8_monitor_drop: assert property (@(posedge clk) disable iff (!rst_n)
      (status_valid && rx_status[ST_DIS]) |-> !accept);
   a_r9_ok_bit: assert property (@(posedge clk) disable iff (!rst_n)
      (status_valid && accept && !rx_status[ST_CRC]) |-> rx_status[ST_OK]);
   a_r9_top_bit_zero: assert property (@(posedge clk) disable iff (!rst_n)
      !rx_status[ST_W-1]);
endmodule

// File: tb/rx_addr_filter_tb_top.sv
module rx_addr_filter_tb_top;
   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        frame_valid = 1'b0;
   logic [47:0] dest_addr = '0, station_addr = '0;
   logic [31:0] dest_crc = '0;
   logic [15:0] frame_len = '0;
   logic        crc_err = 0, align_err = 0, fifo_ovr = 0;
   logic [63:0] hash_table = '0;
   logic        cfg_promisc = 0, cfg_accept_bcast = 0, cfg_accept_mcast = 0;
   logic        cfg_accept_runt = 0, cfg_save_err = 0, cfg_monitor = 0, cfg_auto_tx = 0;
   logic        accept, status_valid, tx_disable;
   logic [7:0]  rx_status;

   int n_checks = 0;
   int n_errors = 0;
   bit done = 0;
   logic m_tx = 1'b0;

   always #4 clk = ~clk;

   rx_addr_filter dut_i (
      .clk(clk), .rst_n(rst_n), .frame_valid(frame_valid), .dest_addr(dest_addr),
      .dest_crc(dest_crc), .frame_len(frame_len), .crc_err(crc_err),
      .align_err(align_err), .fifo_ovr(fifo_ovr), .station_addr(station_addr),
      .hash_table(hash_table), .cfg_promisc(cfg_promisc),
      .cfg_accept_bcast(cfg_accept_bcast), .cfg_accept_mcast(cfg_accept_mcast),
      .cfg_accept_runt(cfg_accept_runt), .cfg_save_err(cfg_save_err),
      .cfg_monitor(cfg_monitor), .cfg_auto_tx(cfg_auto_tx), .accept(accept),
      .rx_status(rx_status), .status_valid(status_valid), .tx_disable(tx_disable)
   );

   task automatic check(string req, logic [63:0] act, logic [63:0] exp);
      n_checks++;
      if (act !== exp) begin
         n_errors++;
         $display("FAIL %s: actual=%0h expected=%0h", req, act, exp);
      end
   endtask

   task automatic finish_run();
      if (!done) begin
         done = 1;
         $display("Result: errors=%0d of %0d checks", n_errors, n_checks);
         $finish;
      end
   endtask

   // expected {accept, status} from the requirement rules
   function automatic logic [8:0] model(logic [47:0] d, logic [47:0] st, logic [31:0] crc,
                                        logic [63:0] tbl, logic [15:0] len,
                                        logic ce, logic ae, logic fo);
      logic grp, bc, hit, pass, acc;
      logic [7:0] s;
      grp = d[0];
      bc  = &d;
      if (bc)       hit = cfg_accept_bcast;                 // R3
      else if (grp) hit = cfg_accept_mcast & tbl[crc[31:26]]; // R4
      else          hit = cfg_promisc | (d == st);          // R1 R2
      pass = hit & ((len >= 16'd64) | cfg_accept_runt)      // R5
                 & (!(ce | ae) | cfg_save_err);             // R6
      acc  = pass & !fo & !cfg_monitor;                     // R7 R8
      s    = '0;
      s[0] = acc & !(ce | ae);                              // R9
      s[1] = ce | ae;
      s[2] = ae;
      s[3] = fo;
      s[4] = pass & cfg_monitor;
      s[5] = grp;
      s[6] = cfg_monitor;
      return {acc, s};
   endfunction

   task automatic frame(string tag, logic [47:0] d, logic [31:0] crc, logic [15:0] len,
                        logic ce, logic ae, logic fo);
      logic [8:0] exp;
      logic [7:0] held_s;
      logic       held_a;
      @(negedge clk);
      dest_addr = d; dest_crc = crc; frame_len = len;
      crc_err = ce; align_err = ae; fifo_ovr = fo;
      frame_valid = 1'b1;
      exp = model(d, station_addr, crc, hash_table, len, ce, ae, fo);
      if (!cfg_auto_tx) m_tx = 1'b0;
      else if (d[0] && !(&d)) begin
         if (crc[31:26] == 6'd62)      m_tx = 1'b1;
         else if (crc[31:26] == 6'd63) m_tx = 1'b0;
      end
      @(negedge clk);
      frame_valid = 1'b0;
      check({tag, " R10 strobe"}, status_valid, 1'b1);
      check({tag, " accept"}, accept, exp[8]);
      check({tag, " R9 status"}, rx_status, exp[7:0]);
      check({tag, " R11 tx_disable"}, tx_disable, m_tx);
      held_a = accept; held_s = rx_status;
      @(negedge clk);
      check({tag, " R10 strobe drop/hold"}, {status_valid, accept, rx_status},
            {1'b0, held_a, held_s});
   endtask

   initial begin
      #(8 * 190000);
      n_errors++;
      $display("FAIL watchdog: actual=hung expected=finished");
      finish_run();
   end

   initial begin
      logic [47:0] d;
      void'($urandom(32'd7391));
      station_addr = 48'h5A_34_12_CD_AB_02;   // byte0 = 0x02 (unicast)
      hash_table   = 64'h8000_0000_0000_0010; // bits 4 and 63 set
      repeat (3) @(negedge clk);
      check("R10 reset outputs", {accept, rx_status, status_valid, tx_disable}, '0);
      rst_n = 1'b1;
      @(negedge clk);

      // R1 exact station match and single-byte mismatches
      frame("R1 exact", station_addr, 32'h0, 16'd100, 0, 0, 0);
      for (int b = 0; b < 6; b++) begin
         d = station_addr;
         d[8*b + 1] = ~d[8*b + 1];
         frame("R1 byte mismatch", d, 32'h0, 16'd100, 0, 0, 0);
      end
      // R2 promiscuous
      cfg_promisc = 1;
      frame("R2 promisc", 48'h11_22_33_44_55_66, 32'h0, 16'd80, 0, 0, 0);
      cfg_promisc = 0;
      // R3 broadcast both ways, hash ignored
      frame("R3 bcast off", '1, 32'hFC00_0000, 16'd80, 0, 0, 0);
      cfg_accept_bcast = 1;
      frame("R3 bcast on", '1, 32'h0, 16'd80, 0, 0, 0);
      // R4 hash hit / miss / option off
      cfg_accept_mcast = 1;
      frame("R4 hash hit", 48'h01_00_5E_00_00_01, {6'd4, 26'h1}, 16'd70, 0, 0, 0);
      frame("R4 hash miss", 48'h01_00_5E_00_00_01, {6'd5, 26'h1}, 16'd70, 0, 0, 0);
      cfg_accept_mcast = 0;
      frame("R4 mcast off", 48'h01_00_5E_00_00_01, {6'd4, 26'h1}, 16'd70, 0, 0, 0);
      // R5 runt boundary
      frame("R5 len 63", station_addr, 32'h0, 16'd63, 0, 0, 0);
      frame("R5 len 64", station_addr, 32'h0, 16'd64, 0, 0, 0);
      cfg_accept_runt = 1;
      frame("R5 runt kept", station_addr, 32'h0, 16'd20, 0, 0, 0);
      cfg_accept_runt = 0;
      // R6 errors
      frame("R6 crc drop", station_addr, 32'h0, 16'd90, 1, 0, 0);
      frame("R6 align drop", station_addr, 32'h0, 16'd90, 0, 1, 0);
      cfg_save_err = 1;
      frame("R6 crc saved", station_addr, 32'h0, 16'd90, 1, 0, 0);
      cfg_save_err = 0;
      // R7 fifo overrun
      frame("R7 fifo", station_addr, 32'h0, 16'd90, 0, 0, 1);
      // R8 monitor
      cfg_monitor = 1;
      frame("R8 monitor pass", station_addr, 32'h0, 16'd90, 0, 0, 0);
      frame("R8 monitor nomatch", 48'h10_00_00_00_00_00, 32'h0, 16'd90, 0, 0, 0);
      cfg_monitor = 0;
      // R11 remote transmitter control
      cfg_auto_tx = 1;
      frame("R11 slot62", 48'h01_00_00_00_00_09, {6'd62, 26'h0}, 16'd70, 0, 0, 0);
      frame("R11 other slot", 48'h01_00_00_00_00_09, {6'd4, 26'h0}, 16'd70, 0, 0, 0);
      frame("R11 bcast slot63", '1, {6'd63, 26'h0}, 16'd70, 0, 0, 0);
      frame("R11 slot63", 48'h01_00_00_00_00_09, {6'd63, 26'h0}, 16'd70, 0, 0, 0);
      frame("R11 slot62 again", 48'h01_00_00_00_00_0B, {6'd62, 26'h5}, 16'd70, 0, 0, 0);
      cfg_auto_tx = 0;
      frame("R11 opt off", station_addr, 32'h0, 16'd70, 0, 0, 0);

      // constrained random mix
      for (int i = 0; i < 1500; i++) begin
         int kind_sel;
         logic [31:0] crc;
         logic [15:0] len;
         kind_sel = $urandom % 4;
         d = {$urandom, $urandom} & 48'hFFFF_FFFF_FFFF;
         case (kind_sel)
            0: d = station_addr;
            1: d[0] = 1'b0;
            2: d = '1;
            default: d[0] = 1'b1;
         endcase
         if (i % 50 == 0) hash_table = {$urandom, $urandom};
         cfg_promisc      = ($urandom % 4) == 0;
         cfg_accept_bcast = $urandom % 2;
         cfg_accept_mcast = $urandom % 2;
         cfg_accept_runt  = ($urandom % 4) == 0;
         cfg_save_err     = ($urandom % 3) == 0;
         cfg_monitor      = ($urandom % 8) == 0;
         cfg_auto_tx      = ($urandom % 4) != 0;
         crc = $urandom;
         if ($urandom % 4 == 0) crc[31:27] = 5'h1F;
         len = 16'(40 + $urandom % 70);
         frame("rand R1 R2 R3 R4 R5 R6 R7 R8", d, crc, len,
               ($urandom % 6) == 0, ($urandom % 6) == 0, ($urandom % 10) == 0);
      end
      finish_run();
   end
endmodule